// File: doc/BRIEF.md
# Half-Duplex Infrared Turnaround Guard

This block decides when a half-duplex infrared link may change direction. The link shares one optical path for both directions, so after a character has gone out the local receiver must stay deaf for a while, because it would otherwise pick up the tail of its own emission. After a character has come in, the local transmitter must likewise wait before it starts, so that the far end has time to turn around. The guard interval is programmed in steps of 100 microseconds. The block counts these steps from a tick pulse that the surrounding logic supplies.

The controller has three states: idle, guarding after a transmission, and guarding after a reception. Each guard counts ticks up to the programmed value. The block does not contain the serial engines. It receives event indications from the transmitter and the receiver. It drives two outputs: a gate for the receiver input and a permit for the transmitter to start a pending character. A new transmit byte loaded during the transmit guard is sent at once, and the guard restarts after its last bit. A new start bit seen during the receive guard holds off the transmitter until the guard has run out again after that character ends.

Top module: `hd_turnaround_ctrl`

## Requirements
- R1: After reset the controller is idle. `rx_enable` is 1, and `tx_start_ok` equals `tx_buf_loaded`.
- R2: A `tx_last_bit` pulse with a clamped setting N>0 drives `rx_enable` to 0. It returns to 1 in the cycle after the edge that samples the Nth `tick_100us` pulse.
- R3: `rx_enable` is 0 in every cycle in which `tx_active` is 1.
- R4: During the transmit guard, a loaded transmit buffer gets `tx_start_ok`=1. While `tx_active` is 1 the guard count is held at zero, and a full N ticks are counted again from the new `tx_last_bit`.
- R5: An `rx_start` pulse is ignored while `rx_enable` is 0. It does not mark a reception in progress, so it does not later withhold `tx_start_ok`.
- R6: While a reception is in progress (between an accepted `rx_start` and `rx_char_done`), `tx_start_ok` is 0.
- R7: After `rx_char_done` with setting N>0, `tx_start_ok` stays 0 until the Nth following tick is sampled. `rx_enable` stays 1 throughout.
- R8: An `rx_start` accepted during the receive guard restarts the guard. N ticks are counted again from the following `rx_char_done`.
- R9: A setting of 0 means no guard. In the cycle after `tx_last_bit`, `rx_enable` is 1. In the cycle after `rx_char_done`, `tx_start_ok` follows `tx_buf_loaded`.
- R10: Settings above 100 (10 ms) act as 100.
- R11: Only `tick_100us` pulses advance a guard. Clock cycles without a tick never end it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100us | input | 1 | One-cycle pulse every 100 microseconds |
| guard_setting | input | 8 | Guard length in 100 microsecond steps (0 to 100, larger values clamped) |
| tx_active | input | 1 | Transmitter is shifting a character out |
| tx_last_bit | input | 1 | One-cycle pulse at the end of the last transmitted bit |
| rx_start | input | 1 | One-cycle pulse when the receiver detects a start bit |
| rx_char_done | input | 1 | One-cycle pulse at the end of the last received bit |
| tx_buf_loaded | input | 1 | Transmit holding buffer contains a character |
| rx_enable | output | 1 | 1 lets the receiver see the line input |
| tx_start_ok | output | 1 | 1 permits the transmitter to start the pending character |

## Verification
The bench uses the default parameters: an 8-bit setting and a 100-step ceiling. Because the tick is an ordinary input that the bench can pulse every other cycle, even the full 10 ms window and the clamp of a setting of 200 fit in a few hundred cycles. Short settings of 1 and 3 let the bench count the exact cycle at which each guard releases, including restarts. A setting of 0 brings the no-guard path within reach.

// File: rtl/hd_turn_pkg.sv
// Package: shared types for the half-duplex turnaround guard.
// Assumes: nothing beyond IEEE 1800-2017.
package hd_turn_pkg;

    // Direction controller state
    typedef enum logic [1:0] {
        DIR_IDLE     = 2'd0,
        DIR_TX_GUARD = 2'd1,
        DIR_RX_GUARD = 2'd2
    } dir_state_e;

endpackage

// File: rtl/hd_guard_limit.sv
// Module: hd_guard_limit
// Converts the raw guard setting into the terminal count used by the timer.
// Values above MAX_STEPS saturate to MAX_STEPS. Purely combinational.
// Assumes: MAX_STEPS fits in SET_W bits and in CNT_W bits.
module hd_guard_limit #(
    parameter int SET_W     = 8,
    parameter int MAX_STEPS = 100,
    parameter int CNT_W     = $clog2(MAX_STEPS + 1)
) (
    input  logic [SET_W-1:0] setting,
    output logic [CNT_W-1:0] limit,
    output logic             limit_zero
);

    localparam logic [SET_W-1:0] MAX_SET = SET_W'(MAX_STEPS);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_STEPS);

    // Saturate the setting and flag the no-guard case
    always_comb begin
        if (setting > MAX_SET) begin
            limit = MAX_CNT;
        end else begin
            limit = CNT_W'(setting);
        end
        limit_zero = (setting == '0);
    end

endmodule

// File: rtl/hd_guard_timer.sv
// Module: hd_guard_timer
// Counts tick pulses while running. It reports expiry in the cycle whose tick
// completes the programmed number of steps. A clear has priority over counting.
// Assumes: limit is nonzero whenever run is asserted with a tick.
module hd_guard_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             expired
);

    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    logic [CNT_W:0] count_next;

    // Next-count value and terminal detection
    always_comb begin
        count_next = {1'b0, count} + ONE;
        expired    = run && tick && (count_next >= {1'b0, limit});
    end

    // Step counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr || expired) begin
            count <= '0;
        end else if (run && tick) begin
            count <= count_next[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/hd_rx_tracker.sv
// Module: hd_rx_tracker
// Remembers that a character is being received. The flag is set by a start bit
// that arrives while the receiver is gated on and cleared by character completion.
// A start bit in the same cycle as a completion wins (back-to-back characters).
// Assumes: rx_start and rx_char_done are single-cycle pulses.
module hd_rx_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_start,
    input  logic rx_char_done,
    input  logic rx_gate,
    output logic rx_busy
);

    logic start_seen;

    // Qualify the start bit with the receiver gate
    always_comb begin
        start_seen = rx_start && rx_gate;
    end

    // Reception-in-progress flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_busy <= 1'b0;
        end else if (start_seen) begin
            rx_busy <= 1'b1;
        end else if (rx_char_done) begin
            rx_busy <= 1'b0;
        end
    end

endmodule

// File: rtl/hd_dir_fsm.sv
// Module: hd_dir_fsm
// Three-state direction controller: idle, guard after transmit, guard after
// receive. It chooses when the guard timer is cleared or running, and it
// derives the receiver gate and the transmit permit.
// Assumes: the transmitter and receiver never finish a character in the same cycle.
// If they do, the transmit event takes precedence.
module hd_dir_fsm
    import hd_turn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_active,
    input  logic       tx_last_bit,
    input  logic       rx_char_done,
    input  logic       rx_busy,
    input  logic       tx_buf_loaded,
    input  logic       limit_zero,
    input  logic       timer_expired,
    output dir_state_e state,
    output logic       timer_clr,
    output logic       timer_run,
    output logic       rx_enable,
    output logic       tx_start_ok
);

    dir_state_e state_next;

    // Timer control: hold at zero while idle, on restart events, and while
    // the opposite side is still moving bits
    always_comb begin
        timer_clr = (state == DIR_IDLE) || tx_last_bit || rx_char_done ||
                    ((state == DIR_TX_GUARD) && tx_active) ||
                    ((state == DIR_RX_GUARD) && rx_busy);
        timer_run = !timer_clr;
    end

    // Next-state selection
    always_comb begin
        state_next = state;
        if (tx_last_bit) begin
            state_next = limit_zero ? DIR_IDLE : DIR_TX_GUARD;
        end else if (rx_char_done) begin
            state_next = limit_zero ? DIR_IDLE : DIR_RX_GUARD;
        end else begin
            unique case (state)
                DIR_IDLE: begin
                    state_next = DIR_IDLE;
                end
                DIR_TX_GUARD: begin
                    if (timer_expired) begin
                        state_next = DIR_IDLE;
                    end
                end
                DIR_RX_GUARD: begin
                    if (timer_expired) begin
                        state_next = DIR_IDLE;
                    end
                end
                default: begin
                    state_next = DIR_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DIR_IDLE;
        end else begin
            state <= state_next;
        end
    end

    // Output gating from the registered state
    always_comb begin
        rx_enable   = !tx_active && (state != DIR_TX_GUARD);
        tx_start_ok = tx_buf_loaded && !rx_busy && (state != DIR_RX_GUARD);
    end

endmodule

// File: rtl/hd_turnaround_ctrl.sv
// Module: hd_turnaround_ctrl (top)
// Half-duplex infrared turnaround guard. It blocks the receiver after a
// transmission and holds back the transmitter after a reception, each for a
// programmable number of 100 microsecond ticks.
// Assumes: the event inputs are single-cycle pulses synchronous to clk.
// The tick comes from a divider elsewhere.
module hd_turnaround_ctrl
    import hd_turn_pkg::*;
#(
    parameter int SET_W     = 8,
    parameter int MAX_STEPS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_100us,
    input  logic [SET_W-1:0] guard_setting,
    input  logic             tx_active,
    input  logic             tx_last_bit,
    input  logic             rx_start,
    input  logic             rx_char_done,
    input  logic             tx_buf_loaded,
    output logic             rx_enable,
    output logic             tx_start_ok
);

    localparam int CNT_W = $clog2(MAX_STEPS + 1);

    logic [CNT_W-1:0] limit;
    logic             limit_zero;
    logic [CNT_W-1:0] t_count;
    logic             t_expired;
    logic             t_clr;
    logic             t_run;
    logic             rx_busy;
    dir_state_e       state;

    hd_guard_limit #(
        .SET_W     (SET_W),
        .MAX_STEPS (MAX_STEPS),
        .CNT_W     (CNT_W)
    ) u_limit (
        .setting    (guard_setting),
        .limit      (limit),
        .limit_zero (limit_zero)
    );

    hd_guard_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (t_clr),
        .run     (t_run),
        .tick    (tick_100us),
        .limit   (limit),
        .count   (t_count),
        .expired (t_expired)
    );

    hd_rx_tracker u_rx_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_start     (rx_start),
        .rx_char_done (rx_char_done),
        .rx_gate      (rx_enable),
        .rx_busy      (rx_busy)
    );

    hd_dir_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_active     (tx_active),
        .tx_last_bit   (tx_last_bit),
        .rx_char_done  (rx_char_done),
        .rx_busy       (rx_busy),
        .tx_buf_loaded (tx_buf_loaded),
        .limit_zero    (limit_zero),
        .timer_expired (t_expired),
        .state         (state),
        .timer_clr     (t_clr),
        .timer_run     (t_run),
        .rx_enable     (rx_enable),
        .tx_start_ok   (tx_start_ok)
    );

endmodule

// File: rtl/hd_turnaround_chk.sv
// Module: hd_turnaround_chk
// Property checker for hd_turnaround_ctrl, attached with bind below.
// Assumes: it sees the top's ports plus its state, busy flag and step count.
module hd_turnaround_chk
    import hd_turn_pkg::*;
#(
    parameter int SET_W     = 8,
    parameter int MAX_STEPS = 100,
    parameter int CNT_W     = $clog2(MAX_STEPS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_100us,
    input logic [SET_W-1:0] guard_setting,
    input logic             tx_active,
    input logic             tx_last_bit,
    input logic             tx_buf_loaded,
    input logic             rx_enable,
    input logic             tx_start_ok,
    input dir_state_e       state,
    input logic             rx_busy,
    input logic [CNT_W-1:0] t_count
);

    // R3
    rx_blocked_while_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !rx_enable);

    // R6
    tx_held_during_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> !tx_start_ok);

    // R7
    tx_held_in_rx_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DIR_RX_GUARD) |-> !tx_start_ok);

    // R9
    zero_guard_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last_bit && (guard_setting == '0)) |=> (tx_active || rx_enable));

    // R11
    tx_guard_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == DIR_TX_GUARD) && !tick_100us && !tx_last_bit) |=> (state == DIR_TX_GUARD));

    // R10
    count_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_count < CNT_W'(MAX_STEPS));

endmodule

bind hd_turnaround_ctrl hd_turnaround_chk #(
    .SET_W     (SET_W),
    .MAX_STEPS (MAX_STEPS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_100us    (tick_100us),
    .guard_setting (guard_setting),
    .tx_active     (tx_active),
    .tx_last_bit   (tx_last_bit),
    .tx_buf_loaded (tx_buf_loaded),
    .rx_enable     (rx_enable),
    .tx_start_ok   (tx_start_ok),
    .state         (state),
    .rx_busy       (rx_busy),
    .t_count       (t_count)
);

// File: tb/hd_turnaround_ctrl_bench.sv
// Directed bench for hd_turnaround_ctrl: one task per scenario.
// Inputs change on falling edges and outputs are sampled on falling edges.
module hd_turnaround_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100us = 1'b0;
    logic [7:0] guard_setting = 8'd3;
    logic       tx_active = 1'b0;
    logic       tx_last_bit = 1'b0;
    logic       rx_start = 1'b0;
    logic       rx_char_done = 1'b0;
    logic       tx_buf_loaded = 1'b0;
    logic       rx_enable;
    logic       tx_start_ok;

    int n_checks = 0;
    int n_fail   = 0;

    hd_turnaround_ctrl u_hd_turnaround_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_100us    (tick_100us),
        .guard_setting (guard_setting),
        .tx_active     (tx_active),
        .tx_last_bit   (tx_last_bit),
        .rx_start      (rx_start),
        .rx_char_done  (rx_char_done),
        .tx_buf_loaded (tx_buf_loaded),
        .rx_enable     (rx_enable),
        .tx_start_ok   (tx_start_ok)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_100us = 1'b1;
            @(negedge clk);
            tick_100us = 1'b0;
            @(negedge clk);
        end
    endtask

    // Transmit one character: busy for a few cycles, then a last-bit pulse
    task automatic send_char;
        tx_active = 1'b1;
        idle_cycles(3);
        chk("R3 rx gated while sending", rx_enable, 1'b0);
        tx_active   = 1'b0;
        tx_last_bit = 1'b1;
        @(negedge clk);
        tx_last_bit = 1'b0;
    endtask

    task automatic pulse_rx_start;
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
    endtask

    task automatic pulse_rx_done;
        rx_char_done = 1'b1;
        @(negedge clk);
        rx_char_done = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset rx_enable", rx_enable, 1'b1);
        chk("R1 reset tx_start_ok idle", tx_start_ok, 1'b0);
        tx_buf_loaded = 1'b1;
        #1;
        chk("R1 tx_start_ok follows buffer", tx_start_ok, 1'b1);
        tx_buf_loaded = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_tx_guard;
        guard_setting = 8'd3;
        send_char();
        chk("R2 rx gated after last bit", rx_enable, 1'b0);
        idle_cycles(40);
        chk("R11 no release without ticks", rx_enable, 1'b0);
        ticks(2);
        chk("R2 still gated after N-1 ticks", rx_enable, 1'b0);
        ticks(1);
        chk("R2 released after N ticks", rx_enable, 1'b1);
    endtask

    task automatic t_rx_ignored;
        guard_setting = 8'd2;
        send_char();
        pulse_rx_start();
        ticks(2);
        chk("R5 rx released", rx_enable, 1'b1);
        tx_buf_loaded = 1'b1;
        #1;
        chk("R5 gated start bit left no reception", tx_start_ok, 1'b1);
        tx_buf_loaded = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_tx_reload;
        guard_setting = 8'd3;
        send_char();
        ticks(2);
        tx_buf_loaded = 1'b1;
        #1;
        chk("R4 reload permitted in tx guard", tx_start_ok, 1'b1);
        tx_buf_loaded = 1'b0;
        tx_active = 1'b1;
        ticks(5);
        chk("R4 held while resending", rx_enable, 1'b0);
        tx_active   = 1'b0;
        tx_last_bit = 1'b1;
        @(negedge clk);
        tx_last_bit = 1'b0;
        ticks(2);
        chk("R4 guard restarted", rx_enable, 1'b0);
        ticks(1);
        chk("R4 released N ticks after new last bit", rx_enable, 1'b1);
    endtask

    task automatic t_rx_guard;
        guard_setting = 8'd3;
        pulse_rx_start();
        tx_buf_loaded = 1'b1;
        #1;
        chk("R6 tx held during reception", tx_start_ok, 1'b0);
        @(negedge clk);
        pulse_rx_done();
        chk("R7 tx held after reception", tx_start_ok, 1'b0);
        chk("R7 rx stays enabled", rx_enable, 1'b1);
        ticks(2);
        chk("R7 tx held N-1 ticks", tx_start_ok, 1'b0);
        ticks(1);
        chk("R7 tx permitted after N ticks", tx_start_ok, 1'b1);
        tx_buf_loaded = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rx_restart;
        guard_setting = 8'd3;
        tx_buf_loaded = 1'b1;
        pulse_rx_start();
        pulse_rx_done();
        ticks(2);
        pulse_rx_start();
        ticks(5);
        chk("R8 held during second character", tx_start_ok, 1'b0);
        pulse_rx_done();
        ticks(2);
        chk("R8 guard restarted", tx_start_ok, 1'b0);
        ticks(1);
        chk("R8 permitted N ticks after second char", tx_start_ok, 1'b1);
        tx_buf_loaded = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_zero;
        guard_setting = 8'd0;
        send_char();
        chk("R9 no guard after tx", rx_enable, 1'b1);
        tx_buf_loaded = 1'b1;
        pulse_rx_start();
        pulse_rx_done();
        chk("R9 no guard after rx", tx_start_ok, 1'b1);
        tx_buf_loaded = 1'b0;
        guard_setting = 8'd1;
        send_char();
        chk("R2 setting 1 gated", rx_enable, 1'b0);
        ticks(1);
        chk("R2 setting 1 released after one tick", rx_enable, 1'b1);
    endtask

    task automatic t_clamp;
        guard_setting = 8'd200;
        send_char();
        ticks(99);
        chk("R10 gated after 99 ticks", rx_enable, 1'b0);
        ticks(1);
        chk("R10 released at 100 ticks", rx_enable, 1'b1);
    endtask

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_guard();
        t_rx_ignored();
        t_tx_reload();
        t_rx_guard();
        t_rx_restart();
        t_zero();
        t_clamp();
        idle_cycles(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule